// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets synchronous logic use an external asynchronous static RAM of 65,536 words by 16 bits. The host side is a request/acknowledge port: it presents an address, write data, a read/write flag and one select bit per byte lane while the controller is idle. The controller turns each request into a complete strobe sequence on the memory pins. These are chip enable, output enable, write enable and one enable per byte lane, all active low, plus the address, the outgoing data and an enable for the data drivers. Reads hand back the data with a one-cycle valid strobe.

All memory timing minimums are given as nanosecond parameters. Together with the clock period they give cycle counts, each rounded up: the access time, the write pulse, data setup, the write cycle and the time the memory needs to stop driving after output enable rises. A write starts with a setup cycle in which output enable is high and the data drivers are already on. Write enable then falls for the pulse, and a recovery phase holds address and data after write enable rises. A read holds chip enable and output enable low for the access time, captures the bus in the following cycle, and then idles the strobes for a bus-release interval before the next request can be taken. The controller's drivers are therefore never on while the memory may still be driving.

Each memory pin is driven from a register loaded from the next-state decode, so no strobe can glitch between cycles.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After synchronous reset (`rst` high on a clock edge) every memory strobe is high, `sram_dq_oe`, `ack` and `rd_valid` are low, and `req_ready` is high.
- R2: A request is taken only on an edge where `req_ready` is high. A `req_valid` presented while the controller is busy has no effect on memory contents.
- R3: Memory is written only while chip enable, write enable and at least one lane enable are all low. Each write-enable low pulse lasts exactly max(ceil(T_PWE_NS/CLK_NS), ceil(T_SD_NS/CLK_NS)) cycles, with the drivers enabled throughout.
- R4: While chip enable stays low, the address does not change. While write enable is low, the outgoing data does not change.
- R5: `req_be[0]` selects lane enable `sram_bl_n[0]` and data bits 7:0, and `req_be[1]` selects `sram_bl_n[1]` and bits 15:8, for reads and for writes. A write with one lane deselected leaves that byte of the word unchanged.
- R6: A read holds chip enable and output enable low with write enable high. `rd_valid` and the captured data appear ceil(T_AA_NS/CLK_NS)+1 cycles after the accepting edge. Deselected lanes read as zero.
- R7: `sram_dq_oe` is never high while the memory drives the bus. After a read, all strobes stay high for max(1, ceil(T_HZ_NS/CLK_NS)) cycles before `req_ready` returns.
- R8: `ack` is a one-cycle pulse, given once per transaction. For a write it rises SETUP_CYC + pulse cycles + recovery cycles after the accepting edge, where recovery is max(1, ceil(T_WC_NS/CLK_NS) − 1 − pulse cycles). For a read it rises together with `rd_valid`.
- R9: A request with `req_be` = 0 lowers no lane enable and leaves memory unchanged. As a read it returns zero. It is still acknowledged.
- R10: During a write, chip enable stays low for at least ceil(T_WC_NS/CLK_NS) consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | Controller idle; request taken on this edge |
| ack | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data, deselected lanes zero |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_bl_n | output | 2 | Lane enables, active low, bit 0 lower |
| sram_addr | output | 16 | Memory address |
| sram_dq_o | output | 16 | Data toward memory |
| sram_dq_oe | output | 1 | Enable for the data drivers |
| sram_dq_i | input | 16 | Data from memory |

## Verification
The bench builds the controller with CLK_NS = 5 and keeps the other timing parameters at their defaults. This gives a 3-cycle access, a 2-cycle write pulse, a 1-cycle recovery and a 2-cycle bus release, so each phase counter runs for several cycles instead of terminating at once. A bus-level memory model places filler values on deselected lanes and on the undriven bus, so lane masking and driver contention become visible. Exact latency checks then cover both the multi-cycle phases and the recovery phase that is held at its lower limit.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_SETUP,
      ST_RD_SAMPLE,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_RECOVER,
      ST_TURN
   } ctl_state_e;

   // ceiling of a nanosecond figure over the clock period
   function automatic int cyc_ceil(input int ns, input int per);
      return (ns + per - 1) / per;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
   parameter int TW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          done
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
   import sram_lane_pkg::*;
#(
   parameter int TW      = 3,
   parameter int D_AA    = 2,
   parameter int D_HZ    = 1,
   parameter int D_WSU   = 1,
   parameter int D_PWE   = 1,
   parameter int D_REC   = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          tmr_done,
   output ctl_state_e    state_q,
   output ctl_state_e    state_nxt,
   output logic          tmr_load,
   output logic [TW-1:0] tmr_val
);

   int dur;

   always_comb begin
      state_nxt = state_q;
      unique case (state_q)
         ST_IDLE:       if (req_valid) state_nxt = req_write ? ST_WR_SETUP : ST_RD_SETUP;
         ST_RD_SETUP:   if (tmr_done)  state_nxt = ST_RD_SAMPLE;
         ST_RD_SAMPLE:                 state_nxt = ST_TURN;
         ST_TURN:       if (tmr_done)  state_nxt = ST_IDLE;
         ST_WR_SETUP:   if (tmr_done)  state_nxt = ST_WR_PULSE;
         ST_WR_PULSE:   if (tmr_done)  state_nxt = ST_WR_RECOVER;
         ST_WR_RECOVER: if (tmr_done)  state_nxt = ST_IDLE;
         default:                      state_nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_nxt)
         ST_RD_SETUP:   dur = D_AA;
         ST_TURN:       dur = D_HZ;
         ST_WR_SETUP:   dur = D_WSU;
         ST_WR_PULSE:   dur = D_PWE;
         ST_WR_RECOVER: dur = D_REC;
         default:       dur = 1;
      endcase
      tmr_load = (state_nxt != state_q);
      tmr_val  = TW'(dur - 1);
   end

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= ST_IDLE;
      else
         state_q <= state_nxt;
   end

endmodule

// File: rtl/sram_lane_pins.sv
module sram_lane_pins
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int LANES  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  ctl_state_e        state_q,
   input  ctl_state_e        state_nxt,
   input  logic              tmr_done,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_bl_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   output logic              host_ack,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   logic              accept;
   logic              nxt_sel, nxt_rd, nxt_wr;
   logic [LANES-1:0]  be_q, be_src, lane_nxt;
   logic [DATA_W-1:0] rd_nxt;

   assign accept  = (state_q == ST_IDLE) && req_valid;
   assign be_src  = accept ? req_be : be_q;
   assign nxt_rd  = (state_nxt == ST_RD_SETUP) || (state_nxt == ST_RD_SAMPLE);
   assign nxt_wr  = (state_nxt == ST_WR_SETUP) || (state_nxt == ST_WR_PULSE) ||
                    (state_nxt == ST_WR_RECOVER);
   assign nxt_sel = nxt_rd || nxt_wr;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_nxt[l]       = !(nxt_sel && be_src[l]);
      assign rd_nxt[l*8 +: 8]  = be_q[l] ? mem_dq_i[l*8 +: 8] : 8'h00;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         be_q      <= '0;
         mem_addr  <= '0;
         mem_dq_o  <= '0;
         mem_ce_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_bl_n  <= '1;
         mem_dq_oe <= 1'b0;
         host_ack  <= 1'b0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
      end else begin
         if (accept) begin
            be_q     <= req_be;
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
         end
         mem_ce_n  <= !nxt_sel;
         mem_oe_n  <= !nxt_rd;
         mem_we_n  <= !(state_nxt == ST_WR_PULSE);
         mem_bl_n  <= lane_nxt;
         mem_dq_oe <= nxt_wr;
         rd_valid  <= (state_q == ST_RD_SAMPLE);
         if (state_q == ST_RD_SAMPLE)
            rd_data <= rd_nxt;
         host_ack  <= (state_q == ST_RD_SAMPLE) ||
                      ((state_q == ST_WR_RECOVER) && tmr_done);
      end
   end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int CLK_NS    = 10,
   parameter int T_AA_NS   = 15,
   parameter int T_WC_NS   = 15,
   parameter int T_PWE_NS  = 10,
   parameter int T_SD_NS   = 8,
   parameter int T_HZ_NS   = 7,
   parameter int SETUP_CYC = 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [DATA_W-1:0]       req_wdata,
   input  logic [DATA_W/8-1:0]     req_be,
   output logic                    req_ready,
   output logic                    ack,
   output logic                    rd_valid,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    sram_ce_n,
   output logic                    sram_oe_n,
   output logic                    sram_we_n,
   output logic [DATA_W/8-1:0]     sram_bl_n,
   output logic [ADDR_W-1:0]       sram_addr,
   output logic [DATA_W-1:0]       sram_dq_o,
   output logic                    sram_dq_oe,
   input  logic [DATA_W-1:0]       sram_dq_i
);

   localparam int LANES = DATA_W / 8;
   localparam int N_AA  = imax(1, cyc_ceil(T_AA_NS, CLK_NS));
   localparam int N_PWE = imax(1, imax(cyc_ceil(T_PWE_NS, CLK_NS), cyc_ceil(T_SD_NS, CLK_NS)));
   localparam int N_WC  = cyc_ceil(T_WC_NS, CLK_NS);
   localparam int N_REC = imax(1, N_WC - SETUP_CYC - N_PWE);
   localparam int N_HZ  = imax(1, cyc_ceil(T_HZ_NS, CLK_NS));
   localparam int MAX_D = imax(imax(N_AA, N_PWE), imax(imax(N_REC, N_HZ), SETUP_CYC));
   localparam int TW    = $clog2(MAX_D + 1);

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("sram_lane_ctrl: DATA_W must be a multiple of 8");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_lane_ctrl: CLK_NS must be positive");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("sram_lane_ctrl: SETUP_CYC must be at least 1");
   end

   ctl_state_e    state_q, state_nxt;
   logic          tmr_load, tmr_done;
   logic [TW-1:0] tmr_val;

   sram_lane_fsm #(
      .TW(TW), .D_AA(N_AA), .D_HZ(N_HZ), .D_WSU(SETUP_CYC),
      .D_PWE(N_PWE), .D_REC(N_REC)
   ) u_fsm (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .tmr_done(tmr_done), .state_q(state_q), .state_nxt(state_nxt),
      .tmr_load(tmr_load), .tmr_val(tmr_val)
   );

   sram_lane_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
   );

   sram_lane_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_pins (
      .clk(clk), .rst(rst), .state_q(state_q), .state_nxt(state_nxt),
      .tmr_done(tmr_done), .req_valid(req_valid), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .mem_dq_i(sram_dq_i),
      .mem_ce_n(sram_ce_n), .mem_oe_n(sram_oe_n), .mem_we_n(sram_we_n),
      .mem_bl_n(sram_bl_n), .mem_addr(sram_addr), .mem_dq_o(sram_dq_o),
      .mem_dq_oe(sram_dq_oe), .host_ack(ack), .rd_valid(rd_valid),
      .rd_data(rd_data)
   );

   assign req_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input logic                clk,
   input logic                rst,
   input logic                req_ready,
   input logic                ack,
   input logic                rd_valid,
   input logic                sram_ce_n,
   input logic                sram_oe_n,
   input logic                sram_we_n,
   input logic [ADDR_W-1:0]   sram_addr,
   input logic [DATA_W-1:0]   sram_dq_o,
   input logic                sram_dq_oe
);

   AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
      !sram_we_n |-> (!sram_ce_n && sram_dq_oe && sram_oe_n)); // R3

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R4

   AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
      (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_dq_o)); // R4

   AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
      !sram_oe_n |-> (sram_we_n && !sram_ce_n)); // R6

   AST_NO_FIGHT: assert property (@(posedge clk) disable iff (rst)
      sram_dq_oe |-> sram_oe_n); // R7

   AST_DRIVE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
      $rose(sram_dq_oe) |-> $past(sram_oe_n)); // R7

   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
      ack |=> !ack); // R8

   AST_RDVALID_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> ack); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (sram_ce_n && !sram_dq_oe)); // R2

endmodule

bind sram_lane_ctrl sram_lane_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .req_ready(req_ready), .ack(ack), .rd_valid(rd_valid),
   .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
   .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;

   localparam int CLKP = 5;   // timing-derivation period given to the block

   function automatic int cdiv(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int E_AA   = cdiv(15, CLKP);
   localparam int E_PWE  = mx(cdiv(10, CLKP), cdiv(8, CLKP));
   localparam int E_WC   = cdiv(15, CLKP);
   localparam int E_REC  = mx(1, E_WC - 1 - E_PWE);
   localparam int E_HZ   = mx(1, cdiv(7, CLKP));
   localparam int E_WLAT = 1 + E_PWE + E_REC;
   localparam int E_RLAT = E_AA + 1;

   logic        clk = 1'b0, rst = 1'b1;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_ready, ack, rd_valid;
   logic [15:0] rd_data;
   logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [1:0]  sram_bl_n;
   logic [15:0] sram_addr, sram_dq_o, sram_dq_i;

   sram_lane_ctrl #(.CLK_NS(CLKP)) i_sram_lane_ctrl (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .req_ready(req_ready), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data),
      .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
      .sram_bl_n(sram_bl_n), .sram_addr(sram_addr), .sram_dq_o(sram_dq_o),
      .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
   );

   always #5 clk = ~clk;

   // bus-level memory model and independent expected image
   logic [15:0] mdl  [0:65535];
   logic [15:0] refm [0:65535];
   logic        mdl_drive;

   assign mdl_drive = !sram_ce_n && !sram_oe_n && sram_we_n && (sram_bl_n != 2'b11);

   always_comb begin
      if (mdl_drive) begin
         sram_dq_i[7:0]  = sram_bl_n[0] ? 8'hC3 : mdl[sram_addr][7:0];
         sram_dq_i[15:8] = sram_bl_n[1] ? 8'hC3 : mdl[sram_addr][15:8];
      end else
         sram_dq_i = 16'h5A5A;
   end

   always @(posedge clk) begin
      if (!sram_ce_n && !sram_we_n) begin
         if (!sram_bl_n[0]) mdl[sram_addr][7:0]  <= sram_dq_o[7:0];
         if (!sram_bl_n[1]) mdl[sram_addr][15:8] <= sram_dq_o[15:8];
      end
   end

   // pin-level monitors, sampled at the falling edge
   int mchecks = 0, mfails = 0;
   int werun = 0, cerun = 0;
   bit wr_seen = 0, ce_prev = 0;
   logic [15:0] addr_prev = '0;

   always @(negedge clk) begin
      if (!rst) begin
         if (sram_dq_oe && mdl_drive) begin
            mfails++; $display("FAIL R7 contention: dq_oe=%0d memory driving (expected no overlap)", sram_dq_oe);
         end
         if (!sram_ce_n && ce_prev && sram_addr != addr_prev) begin
            mfails++; $display("FAIL R4 address moved: act %h exp %h", sram_addr, addr_prev);
         end
         if (!sram_we_n) begin
            werun++;
            if (sram_ce_n || !sram_dq_oe) begin
               mfails++; $display("FAIL R3 we low unqualified: ce_n=%0d dq_oe=%0d exp 0/1", sram_ce_n, sram_dq_oe);
            end
         end else if (werun > 0) begin
            mchecks++;
            if (werun != E_PWE) begin
               mfails++; $display("FAIL R3 we pulse: act %0d exp %0d", werun, E_PWE);
            end
            werun = 0;
         end
         if (!sram_ce_n) begin
            cerun++;
            if (!sram_we_n) wr_seen = 1;
         end else if (cerun > 0) begin
            if (wr_seen) begin
               mchecks++;
               if (cerun < E_WC) begin
                  mfails++; $display("FAIL R10 write cycle: act %0d exp >= %0d", cerun, E_WC);
               end
            end
            cerun = 0; wr_seen = 0;
         end
         ce_prev   = !sram_ce_n;
         addr_prev = sram_addr;
      end
   end

   int checks = 0, fails = 0, wdfail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: act %h exp %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rd(input logic [15:0] a, input logic [1:0] be);
      logic [15:0] r;
      r = '0;
      if (be[0]) r[7:0]  = refm[a][7:0];
      if (be[1]) r[15:8] = refm[a][15:8];
      return r;
   endfunction

   task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] be, input bit poke);
      int n, lim;
      logic [15:0] e;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      e = exp_rd(a, be);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!ack && n < 40) begin
         if (poke && n == 1) begin
            req_valid = 1'b1; req_write = 1'b1; req_wdata = ~d; req_be = 2'b11;
         end
         if (poke && n == 2) req_valid = 1'b0;
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      if (wr) begin
         chk(n == E_WLAT, "R8", "write ack latency", n, E_WLAT);
         if (be[0]) refm[a][7:0]  = d[7:0];
         if (be[1]) refm[a][15:8] = d[15:8];
      end else begin
         chk(n == E_RLAT, "R6", "read latency", n, E_RLAT);
         chk(rd_valid == 1'b1, "R6", "rd_valid with ack", rd_valid, 1);
         chk(rd_data == e, (be == 2'b00) ? "R9" : "R5", "read data", rd_data, e);
      end
      @(negedge clk);
      n++;
      chk(!ack && !rd_valid, "R8", "ack single pulse", {ack, rd_valid}, 0);
      lim = n + 40;
      while (!req_ready && n < lim) begin @(negedge clk); n++; end
      lim = mx(wr ? E_WLAT : E_RLAT + E_HZ, wr ? E_WLAT + 1 : E_RLAT + 1);
      chk(n == lim, "R7", "ready return", n, lim);
   endtask

   initial begin
      #2_000_000;
      wdfail = 1;
      $display("FAIL R8 watchdog: act hung exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks + mchecks, fails + mfails + wdfail);
      $finish;
   end

   initial begin
      logic [15:0] a, d;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 65536; i++) begin
         mdl[i]  = 16'(i * 40503) ^ 16'h1D2B;
         refm[i] = 16'(i * 40503) ^ 16'h1D2B;
      end
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(sram_ce_n && sram_oe_n && sram_we_n && sram_bl_n == 2'b11, "R1", "strobes in reset",
          {sram_ce_n, sram_oe_n, sram_we_n, sram_bl_n}, 5'h1F);
      chk(!sram_dq_oe && !ack && !rd_valid, "R1", "dq_oe/ack/rd_valid in reset",
          {sram_dq_oe, ack, rd_valid}, 0);
      chk(req_ready, "R1", "ready in reset", req_ready, 1);
      rst = 1'b0;

      // directed: full, lower, upper, none, boundaries, poke while busy
      do_op(1, 16'h0000, 16'hBEEF, 2'b11, 0);
      do_op(0, 16'h0000, 16'h0, 2'b11, 0);
      do_op(1, 16'hFFFF, 16'h1234, 2'b01, 0);   // R5 lower only
      do_op(0, 16'hFFFF, 16'h0, 2'b11, 0);
      do_op(1, 16'hFFFF, 16'hA9CD, 2'b10, 0);   // R5 upper only
      do_op(0, 16'hFFFF, 16'h0, 2'b10, 0);
      do_op(0, 16'hFFFF, 16'h0, 2'b01, 0);
      do_op(1, 16'h0040, 16'h7777, 2'b00, 0);   // R9 no lanes
      do_op(0, 16'h0040, 16'h0, 2'b11, 0);
      do_op(0, 16'h0040, 16'h0, 2'b00, 0);      // R9 read returns zero
      do_op(0, 16'h0011, 16'h0, 2'b11, 1);      // R2 request while busy (read)
      do_op(1, 16'h0011, 16'h4321, 2'b11, 1);   // R2 request while busy (write)
      do_op(0, 16'h0011, 16'h0, 2'b11, 0);

      // constrained random mix over a small address pool and the full space
      for (int k = 0; k < 400; k++) begin
         a = ($urandom % 4 == 0) ? 16'($urandom) : {10'h000, 6'($urandom)};
         d = 16'($urandom);
         do_op($urandom % 2 == 1, a, d, 2'($urandom), ($urandom % 8) == 0);
      end

      // final sweep: memory image matches the expected image on the pool
      for (int k = 0; k < 64; k++) do_op(0, 16'(k), 16'h0, 2'b11, 0);

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", checks + mchecks, fails + mfails);
      $finish;
   end

endmodule